// File: doc/BRIEF.md
# Execution Priority and Exception Admission Gate

This block works out the execution priority of a processor core and decides whether a pending exception may preempt what is running. It keeps three pieces of mask state: a one-bit global interrupt mask, a one-bit fault mask and an 8-bit base-priority threshold. Software changes them in two ways. A register-move write puts a data word into a selected register. A change-state command sets or clears one of the two mask bits directly.

The execution priority is the smallest of several candidates. A lower number means a stronger priority, and values are signed. The candidates are:
- a base level one step weaker than any configurable priority, which is always present;
- the active exception's priority, in handler mode only;
- the threshold, when it is nonzero;
- the value 0, while the global mask is set;
- the value -1, while the fault mask is set.

A pending exception is admitted only when its number is strictly below the execution priority. Fixed negative-priority exceptions can therefore get past the masks: -2 gets past both, and -1 gets past the global mask only.

Both outputs are registered. A mask update is taken at one clock edge and reaches the outputs at the next one.

Top module: `xpri_gate`

## Requirements
- R1: After reset the global mask, the fault mask and the threshold are clear. exec_prio reads 256 and accept reads 0.
- R2: In thread mode with no mask active, exec_prio is 256. Any valid pending priority of 255 or below is accepted.
- R3: In handler mode, active_prio takes part in the minimum. exec_prio never exceeds it, and it can pull exec_prio below -1.
- R4: accept is 1 only when pend_valid is 1 and pend_prio is strictly lower than exec_prio. An equal priority is refused.
- R5: While the global mask is set, exec_prio is at most 0. Only priorities -2 and -1 are then accepted.
- R6: While the fault mask is set, exec_prio is at most -1. Only priority -2 is then accepted.
- R7: A nonzero threshold x caps exec_prio at x. A threshold of 0 has no effect.
- R8: Register-move writes are selected by wr_sel: 0 picks the global mask, 1 the fault mask, 2 the threshold and 3 nothing.
  - A write to a mask bit copies wr_data bit 0, so a written 0 clears that mask.
  - A write to the threshold takes all 8 bits.
  - A write with wr_sel 3 changes no state.
- R9: A change-state command selects its target with cps_fault: 0 picks the global mask and 1 the fault mask. It writes cps_set into that mask bit (1 sets it, 0 clears it).
  - When a command and a register move hit the same mask in one cycle, the command wins.
  - When they hit different registers in that cycle, both take effect.
- R10: A mask update is taken at clock edge N and first shows on exec_prio and accept after edge N+1. A change on the pend_* or mode inputs shows after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register-move write strobe |
| wr_sel | input | 2 | Write target: 0 global mask, 1 fault mask, 2 threshold, 3 none |
| wr_data | input | 8 | Write data |
| cps_en | input | 1 | Change-state command strobe |
| cps_fault | input | 1 | Command target: 0 global mask, 1 fault mask |
| cps_set | input | 1 | New value for the targeted mask bit |
| handler_mode | input | 1 | 1 in handler mode, 0 in thread mode |
| active_prio | input | 10 | Signed priority of the active exception |
| pend_valid | input | 1 | A pending exception is presented |
| pend_prio | input | 10 | Signed priority of the pending exception |
| exec_prio | output | 10 | Signed execution priority, registered |
| accept | output | 1 | Pending exception may be taken, registered |

## Verification
The assertions check the following on every cycle:
- each set mask bit caps the next exec_prio value;
- a nonzero threshold and, in handler mode, the active priority bound exec_prio;
- an accept is never raised without a valid pending priority strictly below exec_prio;
- register-move and change-state writes load exactly the value selected, including the rule that a command wins a same-target conflict.

Some behaviour only the bench scenarios can show:
- that each minimum is reached exactly, rather than just bounded;
- that a threshold of 0 and a write with wr_sel 3 change nothing;
- the two-edge latency of a mask update;
- the full sweep of mask combinations against pending priorities at and around each boundary.

// File: rtl/xpri_pkg.sv
package xpri_pkg;

  // register-move write targets
  typedef enum logic [1:0] {
    SEL_GMASK  = 2'd0,
    SEL_FMASK  = 2'd1,
    SEL_THRESH = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;

endpackage

// File: rtl/xpri_mask_regs.sv
module xpri_mask_regs
  import xpri_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic              cps_en,
  input  logic              cps_fault,
  input  logic              cps_set,
  output logic              gm_q,
  output logic              fm_q,
  output logic [PRIO_W-1:0] thr_q
);

  logic mv_gm, mv_fm, mv_thr;
  logic cp_gm, cp_fm;
  logic ld_gm, ld_fm, ld_thr;
  logic gm_d, fm_d;
  logic [PRIO_W-1:0] thr_d;

  // next-state: a change-state command overrides a move to the same bit
  always_comb begin
    mv_gm  = wr_en && (wr_sel == SEL_GMASK);
    mv_fm  = wr_en && (wr_sel == SEL_FMASK);
    mv_thr = wr_en && (wr_sel == SEL_THRESH);
    cp_gm  = cps_en && !cps_fault;
    cp_fm  = cps_en &&  cps_fault;
    ld_gm  = mv_gm || cp_gm;
    ld_fm  = mv_fm || cp_fm;
    ld_thr = mv_thr;
    gm_d   = cp_gm ? cps_set : wr_data[0];
    fm_d   = cp_fm ? cps_set : wr_data[0];
    thr_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gm_q  <= 1'b0;
      fm_q  <= 1'b0;
      thr_q <= '0;
    end else begin
      if (ld_gm)  gm_q  <= gm_d;
      if (ld_fm)  fm_q  <= fm_d;
      if (ld_thr) thr_q <= thr_d;
    end
  end

  p_move_gm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_GMASK && !(cps_en && !cps_fault)) |=> (gm_q == $past(wr_data[0])));

  p_move_fm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_FMASK && !(cps_en && cps_fault)) |=> (fm_q == $past(wr_data[0])));

  p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_THRESH) |=> $stable(thr_q));

  p_cps_gm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cps_en && !cps_fault) |=> (gm_q == $past(cps_set)));

  p_cps_fm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cps_en && cps_fault) |=> (fm_q == $past(cps_set)));

endmodule

// File: rtl/xpri_prio_min.sv
module xpri_prio_min #(
  parameter int PRIO_W = 8,
  parameter int EP_W   = 10
) (
  input  logic                   gm,
  input  logic                   fm,
  input  logic [PRIO_W-1:0]      thr,
  input  logic                   handler_mode,
  input  logic signed [EP_W-1:0] active_prio,
  output logic signed [EP_W-1:0] exec_nxt
);

  localparam int NSRC = 4;
  localparam logic signed [EP_W-1:0] BASE_LVL = EP_W'(1 << PRIO_W);

  logic signed [EP_W-1:0] cand  [NSRC];
  logic        [NSRC-1:0] use_c;
  logic signed [EP_W-1:0] stage [NSRC+1];

  // candidate sources; the base level seeds the chain
  assign cand[0]  = active_prio;
  assign use_c[0] = handler_mode;
  assign cand[1]  = $signed(EP_W'(thr));
  assign use_c[1] = (thr != '0);
  assign cand[2]  = '0;
  assign use_c[2] = gm;
  assign cand[3]  = '1;
  assign use_c[3] = fm;

  assign stage[0] = BASE_LVL;

  for (genvar i = 0; i < NSRC; i++) begin : g_min
    assign stage[i+1] = (use_c[i] && (cand[i] < stage[i])) ? cand[i] : stage[i];
  end

  assign exec_nxt = stage[NSRC];

endmodule

// File: rtl/xpri_accept_reg.sv
module xpri_accept_reg #(
  parameter int PRIO_W = 8,
  parameter int EP_W   = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [EP_W-1:0] exec_nxt,
  input  logic                   pend_valid,
  input  logic signed [EP_W-1:0] pend_prio,
  output logic signed [EP_W-1:0] exec_q,
  output logic                   acc_q
);

  localparam logic signed [EP_W-1:0] BASE_LVL = EP_W'(1 << PRIO_W);

  logic acc_d;

  always_comb begin
    acc_d = pend_valid && (pend_prio < exec_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= BASE_LVL;
      acc_q  <= 1'b0;
    end else begin
      exec_q <= exec_nxt;
      acc_q  <= acc_d;
    end
  end

  p_accept_strict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> ($past(pend_valid) && ($past(pend_prio) < exec_q)));

endmodule

// File: rtl/xpri_gate.sv
module xpri_gate #(
  parameter int PRIO_W = 8,
  parameter int EP_W   = 10
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [PRIO_W-1:0]      wr_data,
  input  logic                   cps_en,
  input  logic                   cps_fault,
  input  logic                   cps_set,
  input  logic                   handler_mode,
  input  logic signed [EP_W-1:0] active_prio,
  input  logic                   pend_valid,
  input  logic signed [EP_W-1:0] pend_prio,
  output logic signed [EP_W-1:0] exec_prio,
  output logic                   accept
);

  logic rs0_q, rs1_q, rst_n_s;
  logic gm_q, fm_q;
  logic [PRIO_W-1:0] thr_q;
  logic signed [EP_W-1:0] exec_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_n_s = rs1_q;

  xpri_mask_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cps_en    (cps_en),
    .cps_fault (cps_fault),
    .cps_set   (cps_set),
    .gm_q      (gm_q),
    .fm_q      (fm_q),
    .thr_q     (thr_q)
  );

  xpri_prio_min #(.PRIO_W(PRIO_W), .EP_W(EP_W)) u_min (
    .gm           (gm_q),
    .fm           (fm_q),
    .thr          (thr_q),
    .handler_mode (handler_mode),
    .active_prio  (active_prio),
    .exec_nxt     (exec_nxt)
  );

  xpri_accept_reg #(.PRIO_W(PRIO_W), .EP_W(EP_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .exec_nxt   (exec_nxt),
    .pend_valid (pend_valid),
    .pend_prio  (pend_prio),
    .exec_q     (exec_prio),
    .acc_q      (accept)
  );

  p_gmask_cap_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    gm_q |=> (exec_prio <= 0));

  p_fault_cap_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    fm_q |=> (exec_prio <= -1));

  p_thresh_cap_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (thr_q != '0) |=> (exec_prio <= $signed(EP_W'($past(thr_q)))));

  p_handler_cap_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    handler_mode |=> (exec_prio <= $past(active_prio)));

endmodule

// File: tb/xpri_gate_test.sv
`timescale 1ns/1ps
module xpri_gate_test;

  logic clk = 1'b0;
  logic arst_n;
  logic wr_en, cps_en, cps_fault, cps_set, handler_mode, pend_valid;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic signed [9:0] active_prio, pend_prio, exec_prio;
  logic accept;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xpri_gate uut (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cps_en(cps_en), .cps_fault(cps_fault), .cps_set(cps_set),
    .handler_mode(handler_mode), .active_prio(active_prio),
    .pend_valid(pend_valid), .pend_prio(pend_prio),
    .exec_prio(exec_prio), .accept(accept)
  );

  task automatic chk(string tag, int act_v, int exp_v);
    n_run++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mv(int sel, int data);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
    step();
    wr_en = 1'b0;
  endtask

  task automatic cps(bit fault, bit setv);
    cps_en = 1'b1; cps_fault = fault; cps_set = setv;
    step();
    cps_en = 1'b0;
  endtask

  // present a pending priority, let it register, then compare
  task automatic probe(bit v, int p, int exp_e, string te, string ta);
    pend_valid = v; pend_prio = 10'(p);
    step();
    chk(te, int'(exec_prio), exp_e);
    chk(ta, int'(accept), (v && p < exp_e) ? 1 : 0);
  endtask

  function automatic int ref_exec(bit g, bit f, int t, bit h, int a);
    int m = 256;
    if (h && a < m) m = a;
    if (t != 0 && t < m) m = t;
    if (g && 0 < m) m = 0;
    if (f && -1 < m) m = -1;
    return m;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; cps_en = 0; cps_fault = 0;
    cps_set = 0; handler_mode = 0; active_prio = 0; pend_valid = 0; pend_prio = 0;
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 exec", int'(exec_prio), 256);
    chk("R1 accept", int'(accept), 0);

    // sweep of mask combinations (R2 R3 R5 R6 R7 R4)
    for (int cfg = 0; cfg < 16; cfg++) begin
      bit g = cfg[0];
      bit f = cfg[1];
      int t = cfg[2] ? 64 : 0;
      bit h = cfg[3];
      int e;
      int pl[7];
      string tg;
      mv(0, g); mv(1, f); mv(2, t);
      handler_mode = h; active_prio = 10'sd100;
      e = ref_exec(g, f, t, h, 100);
      tg = f ? "R6" : g ? "R5" : (t != 0) ? "R7" : h ? "R3" : "R2";
      pl = '{-2, -1, 0, t, t - 1, t + 1, 255};
      for (int k = 0; k < 7; k++) probe(1'b1, pl[k], e, tg, "R4 sweep accept");
    end
    mv(0, 0); mv(1, 0); mv(2, 0); handler_mode = 0;

    // R4 invalid pending and equal priority
    probe(1'b0, -2, 256, "R4 invalid exec", "R4 invalid accept");
    probe(1'b1, 256, 256, "R4 equal exec", "R4 equal accept");
    handler_mode = 1; active_prio = 10'sd5;
    probe(1'b1, 5, 5, "R3 exec", "R4 equal active");
    probe(1'b1, 4, 5, "R3 exec", "R4 below active");
    // R3 active -2 goes below the fault mask level
    active_prio = -10'sd2; mv(1, 1);
    probe(1'b1, -2, -2, "R3 below fault", "R3 nmi refused");
    mv(1, 0); handler_mode = 0;

    // R8 move copies bit 0; writing 0 clears
    mv(0, 8'h03);
    probe(1'b1, -1, 0, "R8 gmask set", "R8 accept");
    mv(0, 8'hFE);
    probe(1'b1, 200, 256, "R8 gmask cleared", "R8 accept");
    mv(1, 8'h01);
    probe(1'b1, -1, -1, "R8 fmask set", "R8 accept");
    mv(1, 8'h00);
    mv(2, 8'hC8);
    probe(1'b1, 199, 200, "R8 thresh full byte", "R8 accept");
    mv(2, 0);
    mv(3, 8'hFF);
    probe(1'b1, 255, 256, "R8 sel3 ignored", "R8 sel3 accept");

    // R9 change-state commands
    cps(1'b0, 1'b1);
    probe(1'b1, 0, 0, "R9 cps gm set", "R9 accept");
    cps(1'b1, 1'b1);
    probe(1'b1, -1, -1, "R9 cps fm set", "R9 accept");
    cps(1'b1, 1'b0);
    probe(1'b1, -1, 0, "R9 cps fm clear", "R9 accept");
    cps(1'b0, 1'b0);
    probe(1'b1, 0, 256, "R9 cps gm clear", "R9 accept");
    // same target: command wins
    wr_en = 1; wr_sel = 2'd0; wr_data = 8'h01; cps_en = 1; cps_fault = 0; cps_set = 0;
    step(); wr_en = 0; cps_en = 0;
    probe(1'b1, 100, 256, "R9 conflict cps wins", "R9 accept");
    // different targets: both apply
    wr_en = 1; wr_sel = 2'd1; wr_data = 8'h01; cps_en = 1; cps_fault = 0; cps_set = 1;
    step(); wr_en = 0; cps_en = 0;
    probe(1'b1, -1, -1, "R9 both applied", "R9 accept");
    cps(1'b1, 1'b0);
    probe(1'b1, -1, 0, "R9 gm kept", "R9 accept");
    cps(1'b0, 1'b0);
    step();

    // R10 latency: mask taken at edge N, visible after edge N+1
    pend_valid = 1; pend_prio = 10'sd5;
    wr_en = 1; wr_sel = 2'd0; wr_data = 8'h01;
    step(); wr_en = 0;
    chk("R10 old exec", int'(exec_prio), 256);
    chk("R10 old accept", int'(accept), 1);
    step();
    chk("R10 new exec", int'(exec_prio), 0);
    chk("R10 new accept", int'(accept), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule